// File: doc/BRIEF.md
# Variable-pulse-width bus symbol decoder

This block turns the filtered receive line of a variable-pulse-width multiplexed bus into a stream of bus symbols and data bytes. A 1 MHz tick enable provides the time base. Every confirmed pulse, active or passive, is measured in ticks. Its width and level then classify it as a data bit, start of frame, end of data, end of frame, inter-frame separation or break. A frame-tracking stage drops everything seen before a start of frame, shifts accepted bits into bytes, and reports protocol violations.

The decoder input is chosen by a loopback select and a receive-polarity control. A debounce stage in front of the pulse timer drops glitches shorter than the noise limit. A 4X mode serves the faster receive-only rate: every timing threshold is divided by four, with integer truncation. Symbols come out on a plain one-cycle strobe with a 3-bit code. Completed bytes leave on a valid/ready port. The bus cannot be stalled, so back-pressure only holds the current byte. While `out_valid` is high and `out_ready` is low, `out_data` stays unchanged. If another byte completes before the handshake, it replaces the held byte. With `out_ready` tied high, `out_valid` becomes a one-cycle strobe.

Top module: `vpw_symbol_decoder`

## Requirements
- R1: With `loop_en` = 1 the decoder follows `tx_loop`, and activity on `rx_pin` produces no symbol. With `loop_en` = 0 it follows `rx_pin`.
- R2: With `rx_pol` = 0 a low `rx_pin` counts as the active level. With `rx_pol` = 1 a high `rx_pin` is active.
- R3: A level change that lasts under 34 ticks produces no symbol and leaves `idle` unchanged.
- R4: An active pulse of 34–95 ticks gives code 0 (zero bit). One of 96–162 ticks gives code 1 (one bit). One of 163–238 ticks gives code 2 (start of frame).
- R5: A passive pulse of 34–95 ticks gives code 1. One of 96–162 ticks gives code 0. A passive period inside a frame gives code 3 (end of data) when it reaches 163 ticks, then code 4 (end of frame) at 239 ticks, after which the frame is closed.
- R6: Before the first start of frame, and after a frame has been closed or aborted, bits produce no symbol and no byte.
- R7: Accepted bits are shifted in first-received-as-MSB. `out_valid` rises in the cycle that reports the eighth bit of a byte.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid` stays high and `out_data` stays stable until another byte completes, which replaces it. A handshake with no new byte clears `out_valid`.
- R9: A passive period reaching 280 ticks gives code 5 (inter-frame separation) and sets `idle`, unless `idle` is already set. `idle` clears when the line turns active.
- R10: An active period reaching 239 ticks gives code 6 (break) together with `bad_stb`, and aborts any frame.
- R11: An end of data that arrives with a partial byte gives code 7 (invalid) with `bad_stb` instead of code 3. Bits are then ignored until the next start of frame.
- R12: With `rate_4x` = 1 every threshold is divided by four, truncated: noise 8, short 24, long 40, break and end of frame 59, end of data 40, separation 70.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse from the 1 MHz time reference |
| rx_pin | input | 1 | External receive line |
| tx_loop | input | 1 | Internal transmit signal used in loopback |
| loop_en | input | 1 | 1 = decode `tx_loop`, 0 = decode `rx_pin` |
| rx_pol | input | 1 | 1 = pin high is active, 0 = pin low is active |
| rate_4x | input | 1 | 1 = thresholds divided by four |
| out_ready | input | 1 | Byte consumer ready |
| out_valid | output | 1 | Byte available |
| out_data | output | DW | Received byte, first bit in MSB |
| sym_stb | output | 1 | One-cycle symbol report |
| sym_code | output | 3 | Symbol code (see R4, R5, R9–R11) |
| bad_stb | output | 1 | Break or invalid symbol reported |
| idle | output | 1 | Inter-frame separation seen, bus not active since |

## Verification
A wrong frame state shows up as missing or extra symbol reports. Either a start of frame fails to admit the next bits, or bits after an abort are still reported. The first such error appears within one bit time, roughly 100 ticks. A wrong shift count or bit order shows up at the eighth bit, as a misplaced `out_valid` or a wrong `out_data`. Threshold or filter errors change a code on the very pulse that crosses the boundary, and `idle` errors show 280 ticks into a passive period. A scoreboard therefore compares every reported symbol, every byte, and the `bad_stb` that goes with each symbol, in order.

// File: rtl/vpw_pkg.sv
package vpw_pkg;
  typedef enum logic [2:0] {
    SYM_BIT0 = 3'd0,
    SYM_BIT1 = 3'd1,
    SYM_SOF  = 3'd2,
    SYM_EOD  = 3'd3,
    SYM_EOF  = 3'd4,
    SYM_IFS  = 3'd5,
    SYM_BRK  = 3'd6,
    SYM_BAD  = 3'd7
  } vpw_sym_e;
endpackage

// File: rtl/vpw_line_select.sv
module vpw_line_select #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic tx_loop,
  input  logic loop_en,
  input  logic rx_pol,
  output logic line
);
  logic src;
  logic [SYNC-1:0] stage;

  // polarity 1 passes the pin, 0 inverts it; loopback bypasses both
  assign src  = loop_en ? tx_loop : (rx_pin ^ ~rx_pol);
  assign line = stage[SYNC-1];

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage <= '0;
        else        stage <= src;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage <= '0;
        else        stage <= {stage[SYNC-2:0], src};
    end
  endgenerate
endmodule

// File: rtl/vpw_pulse_timer.sv
module vpw_pulse_timer #(
  parameter int WW      = 9,
  parameter int T_NOISE = 34,
  parameter int CAP     = 280
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          fast,
  input  logic          line,
  output logic          m_stb,
  output logic          m_level,
  output logic          m_end,
  output logic [WW-1:0] m_width
);
  localparam logic [WW-1:0] NZ_N = WW'(T_NOISE);
  localparam logic [WW-1:0] NZ_F = WW'(T_NOISE / 4);
  localparam logic [WW-1:0] CAPV = WW'(CAP);

  logic          lvl;
  logic [WW-1:0] fcnt, pcnt, nz;
  logic          differs, confirm;

  assign nz      = fast ? NZ_F : NZ_N;
  assign differs = (line != lvl);
  assign confirm = differs && ((fcnt + 1'b1) >= nz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= 1'b0;
      fcnt    <= '0;
      pcnt    <= '0;
      m_stb   <= 1'b0;
      m_level <= 1'b0;
      m_end   <= 1'b0;
      m_width <= '0;
    end else begin
      m_stb <= tick;
      if (tick) begin
        m_level <= lvl;
        m_width <= pcnt + 1'b1;
        m_end   <= confirm;
        if (confirm) begin
          lvl  <= line;
          fcnt <= '0;
          pcnt <= '0;
        end else begin
          fcnt <= differs ? fcnt + 1'b1 : '0;
          if (pcnt < CAPV) pcnt <= pcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vpw_symbol_classify.sv
module vpw_symbol_classify
  import vpw_pkg::*;
#(
  parameter int WW      = 9,
  parameter int T_SHORT = 96,
  parameter int T_LONG  = 163,
  parameter int T_BRK   = 239,
  parameter int T_EOD   = 163,
  parameter int T_EOF   = 239,
  parameter int T_IFS   = 280
) (
  input  logic          fast,
  input  logic          m_stb,
  input  logic          m_level,
  input  logic          m_end,
  input  logic [WW-1:0] m_width,
  output logic          ev_stb,
  output vpw_sym_e      ev_code,
  output logic          go_active
);
  localparam int NT = 6;
  localparam int BASE [NT] = '{T_SHORT, T_LONG, T_BRK, T_EOD, T_EOF, T_IFS};

  logic [WW-1:0] thr [NT];

  generate
    for (genvar i = 0; i < NT; i++) begin : g_thr
      localparam logic [WW-1:0] NV = WW'(BASE[i]);
      localparam logic [WW-1:0] FV = WW'(BASE[i] / 4);
      assign thr[i] = fast ? FV : NV;
    end
  endgenerate

  assign go_active = m_stb && m_end && !m_level;

  always_comb begin
    ev_stb  = 1'b0;
    ev_code = SYM_BAD;
    if (m_stb) begin
      if (m_level) begin
        if (m_width == thr[2]) begin
          ev_stb  = 1'b1;
          ev_code = SYM_BRK;
        end else if (m_end && m_width < thr[2]) begin
          ev_stb  = 1'b1;
          ev_code = (m_width < thr[0]) ? SYM_BIT0 :
                    (m_width < thr[1]) ? SYM_BIT1 : SYM_SOF;
        end
      end else begin
        if (m_width == thr[3]) begin
          ev_stb = 1'b1; ev_code = SYM_EOD;
        end else if (m_width == thr[4]) begin
          ev_stb = 1'b1; ev_code = SYM_EOF;
        end else if (m_width == thr[5]) begin
          ev_stb = 1'b1; ev_code = SYM_IFS;
        end else if (m_end && m_width < thr[3]) begin
          ev_stb  = 1'b1;
          ev_code = (m_width < thr[0]) ? SYM_BIT1 : SYM_BIT0;
        end
      end
    end
  end
endmodule

// File: rtl/vpw_byte_framer.sv
module vpw_byte_framer
  import vpw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_stb,
  input  vpw_sym_e      ev_code,
  input  logic          go_active,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          sym_stb,
  output logic [2:0]    sym_code,
  output logic          bad_stb,
  output logic          idle
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST = BW'(DW - 1);

  logic          in_frame;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sh, sh_nx;

  assign sh_nx = {sh[DW-2:0], (ev_code == SYM_BIT1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame  <= 1'b0;
      bitn      <= '0;
      sh        <= '0;
      idle      <= 1'b0;
      sym_stb   <= 1'b0;
      sym_code  <= '0;
      bad_stb   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      sym_stb <= 1'b0;
      bad_stb <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (go_active) idle <= 1'b0;
      if (ev_stb) begin
        case (ev_code)
          SYM_SOF: begin
            in_frame <= 1'b1;
            bitn     <= '0;
            sym_stb  <= 1'b1;
            sym_code <= SYM_SOF;
          end
          SYM_BIT0, SYM_BIT1: if (in_frame) begin
            sh       <= sh_nx;
            sym_stb  <= 1'b1;
            sym_code <= ev_code;
            if (bitn == LAST) begin
              bitn      <= '0;
              out_valid <= 1'b1;
              out_data  <= sh_nx;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
          SYM_EOD: if (in_frame) begin
            sym_stb <= 1'b1;
            if (bitn != '0) begin
              sym_code <= SYM_BAD;
              bad_stb  <= 1'b1;
              in_frame <= 1'b0;
              bitn     <= '0;
            end else begin
              sym_code <= SYM_EOD;
            end
          end
          SYM_EOF: if (in_frame) begin
            sym_stb  <= 1'b1;
            sym_code <= SYM_EOF;
            in_frame <= 1'b0;
          end
          SYM_IFS: if (!idle) begin
            sym_stb  <= 1'b1;
            sym_code <= SYM_IFS;
            idle     <= 1'b1;
          end
          SYM_BRK: begin
            sym_stb  <= 1'b1;
            sym_code <= SYM_BRK;
            bad_stb  <= 1'b1;
            in_frame <= 1'b0;
            bitn     <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vpw_symbol_decoder.sv
module vpw_symbol_decoder
  import vpw_pkg::*;
#(
  parameter int DW      = 8,
  parameter int SYNC    = 2,
  parameter int T_NOISE = 34,
  parameter int T_SHORT = 96,
  parameter int T_LONG  = 163,
  parameter int T_BRK   = 239,
  parameter int T_EOD   = 163,
  parameter int T_EOF   = 239,
  parameter int T_IFS   = 280
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_pin,
  input  logic          tx_loop,
  input  logic          loop_en,
  input  logic          rx_pol,
  input  logic          rate_4x,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          sym_stb,
  output logic [2:0]    sym_code,
  output logic          bad_stb,
  output logic          idle
);
  localparam int WW = $clog2(T_IFS + 2);

  logic          line, m_stb, m_level, m_end, ev_stb, go_active;
  logic [WW-1:0] m_width;
  vpw_sym_e      ev_code;

  vpw_line_select #(.SYNC(SYNC)) u_sel (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_loop(tx_loop),
    .loop_en(loop_en), .rx_pol(rx_pol), .line(line));

  vpw_pulse_timer #(.WW(WW), .T_NOISE(T_NOISE), .CAP(T_IFS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fast(rate_4x), .line(line),
    .m_stb(m_stb), .m_level(m_level), .m_end(m_end), .m_width(m_width));

  vpw_symbol_classify #(.WW(WW), .T_SHORT(T_SHORT), .T_LONG(T_LONG),
    .T_BRK(T_BRK), .T_EOD(T_EOD), .T_EOF(T_EOF), .T_IFS(T_IFS)) u_cls (
    .fast(rate_4x), .m_stb(m_stb), .m_level(m_level), .m_end(m_end),
    .m_width(m_width), .ev_stb(ev_stb), .ev_code(ev_code),
    .go_active(go_active));

  vpw_byte_framer #(.DW(DW)) u_frm (
    .clk(clk), .rst_n(rst_n), .ev_stb(ev_stb), .ev_code(ev_code),
    .go_active(go_active), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .sym_stb(sym_stb), .sym_code(sym_code),
    .bad_stb(bad_stb), .idle(idle));
endmodule

// File: rtl/vpw_decoder_checker.sv
module vpw_decoder_checker
  import vpw_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_ready,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          sym_stb,
  input logic [2:0]    sym_code,
  input logic          bad_stb,
  input logic          idle
);
  logic is_bit, is_bad;
  assign is_bit = sym_stb && (sym_code == SYM_BIT0 || sym_code == SYM_BIT1);
  assign is_bad = sym_stb && (sym_code == SYM_BRK || sym_code == SYM_BAD);

  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) || is_bit);

  assert_byte_on_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> is_bit);

  assert_idle_on_sep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> sym_stb && sym_code == SYM_IFS);

  assert_bad_has_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_stb |-> is_bad);

  assert_code_has_bad_R11: assert property (@(posedge clk) disable iff (!rst_n)
    is_bad |-> bad_stb);
endmodule

bind vpw_symbol_decoder vpw_decoder_checker #(.DW(DW)) u_chk (.*);

// File: tb/sim_vpw_symbol_decoder.sv
module sim_vpw_symbol_decoder;
  // tick every 10 clocks shortens the run; one tick stands for 1 us
  localparam int TICK_DIV = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic rx_pin = 1'b0, tx_loop = 1'b0, loop_en = 1'b0, rx_pol = 1'b1;
  logic rate_4x = 1'b0, out_ready = 1'b1;
  logic out_valid, sym_stb, bad_stb, idle;
  logic [7:0] out_data;
  logic [2:0] sym_code;

  int total = 0, bad = 0, tdiv = 0;
  logic ph = 1'b0;
  bit done = 0;
  logic [2:0] exp_sym[$];
  logic [7:0] exp_byte[$];

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_DIV - 1);
  end

  vpw_symbol_decoder u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_pin(rx_pin),
    .tx_loop(tx_loop), .loop_en(loop_en), .rx_pol(rx_pol),
    .rate_4x(rate_4x), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .sym_stb(sym_stb), .sym_code(sym_code),
    .bad_stb(bad_stb), .idle(idle));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected symbols and bytes as the design reports them
  always @(negedge clk) if (rst_n && !done) begin
    if (sym_stb) begin
      if (exp_sym.size() == 0) check(0, "R3/R6 unexpected symbol", sym_code, 8);
      else begin
        automatic logic [2:0] e = exp_sym.pop_front();
        check(sym_code == e, "R4/R5/R9/R10/R11/R12 symbol code", sym_code, e);
        check(bad_stb == (e >= 3'd6), "R10/R11 bad_stb", bad_stb, e >= 3'd6);
      end
    end
    if (out_valid && out_ready) begin
      if (exp_byte.size() == 0) check(0, "R6 unexpected byte", out_data, 256);
      else begin
        automatic logic [7:0] eb = exp_byte.pop_front();
        check(out_data == eb, "R7 byte value", out_data, eb);
      end
    end
  end

  task automatic hold_us(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic drive(input logic act);
    if (loop_en) tx_loop = act;
    else         rx_pin  = rx_pol ? act : ~act;
  endtask

  task automatic pulse(input logic act, input int us);
    drive(act);
    hold_us(us);
  endtask

  task automatic sof(input int us);
    exp_sym.push_back(3'd2);
    pulse(1'b1, us);
    ph = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] v, input int n, input int sh,
                           input int lg, input bit push_byte);
    for (int i = n - 1; i >= 0; i--) begin
      automatic int w = (ph ^ v[i]) ? sh : lg;
      exp_sym.push_back(v[i] ? 3'd1 : 3'd0);
      pulse(ph, (ph ? (v[i] ? lg : sh) : (v[i] ? sh : lg)));
      if (w < 0) $display("unreachable");
      ph = ~ph;
    end
    if (push_byte) exp_byte.push_back(v);
  endtask

  task automatic end_frame(input int us);
    exp_sym.push_back(3'd3);
    exp_sym.push_back(3'd4);
    exp_sym.push_back(3'd5);
    pulse(1'b0, us);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(!out_valid && !sym_stb && !idle, "reset state", {out_valid, sym_stb, idle}, 0);
    rst_n = 1'b1;
    // R9: passive from reset reaches separation
    exp_sym.push_back(3'd5);
    hold_us(330);
    check(idle == 1'b1, "R9 idle after separation", idle, 1);
    // R3: glitch below noise limit
    pulse(1'b1, 20);
    pulse(1'b0, 60);
    check(idle == 1'b1, "R3 glitch ignored, idle kept", idle, 1);
    // R4/R5/R7: nominal frame
    sof(200);
    check(idle == 1'b0, "R9 idle cleared by activity", idle, 0);
    send_bits(8'hA5, 8, 64, 128, 1);
    end_frame(330);
    check(idle == 1'b1, "R9 idle after frame", idle, 1);
    // R4/R5: widths near range edges
    sof(170);
    send_bits(8'h96, 8, 40, 150, 1);
    end_frame(330);
    // R2 + R8: inverted pin, consumer stalled over two bytes
    @(negedge clk);
    rx_pol = 1'b0; rx_pin = 1'b1; out_ready = 1'b0;
    sof(200);
    send_bits(8'h3C, 8, 64, 128, 0);
    send_bits(8'hC3, 8, 64, 128, 1);
    end_frame(330);
    check(out_valid == 1'b1, "R8 valid held", out_valid, 1);
    check(out_data == 8'hC3, "R8 newer byte replaces held one", out_data, 8'hC3);
    @(negedge clk) out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 handshake clears valid", out_valid, 0);
    @(negedge clk);
    rx_pol = 1'b1; rx_pin = 1'b0;
    // R1: loopback, pin held active and ignored
    @(negedge clk);
    loop_en = 1'b1; tx_loop = 1'b0;
    @(negedge clk) rx_pin = 1'b1;
    sof(200);
    send_bits(8'h0F, 8, 64, 128, 1);
    end_frame(330);
    @(negedge clk) rx_pin = 1'b0;
    @(negedge clk) loop_en = 1'b0;
    // R11 + R6: partial byte then ignored bits
    sof(200);
    send_bits(8'h0B, 4, 64, 128, 0);
    exp_sym.push_back(3'd7);
    pulse(1'b0, 200);
    pulse(1'b1, 64);
    pulse(1'b0, 64);
    pulse(1'b1, 128);
    exp_sym.push_back(3'd5);
    pulse(1'b0, 330);
    // R10: break
    exp_sym.push_back(3'd6);
    pulse(1'b1, 260);
    exp_sym.push_back(3'd5);
    pulse(1'b0, 330);
    // R12: fast mode frame
    @(negedge clk) rate_4x = 1'b1;
    sof(50);
    send_bits(8'h5A, 8, 16, 32, 1);
    end_frame(100);
    check(idle == 1'b1, "R12 idle in fast mode", idle, 1);
    hold_us(20);
    check(exp_sym.size() == 0, "R4/R5 all symbols seen", exp_sym.size(), 0);
    check(exp_byte.size() == 0, "R7 all bytes seen", exp_byte.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule